// File: doc/BRIEF.md
# Overlapping 1010 Serial Pattern Detector

This block watches a single serial data bit, sampled once per clock, and raises a one-bit flag whenever the four most recent bits form the pattern 1, 0, 1, 0 in order of arrival. Matches may overlap. After a hit, the trailing "1, 0" of that match already counts as the first half of the next one, so the stream 1,0,1,0,1,0 gives two hits.

The controller is a Mealy machine with the fewest states that still track the pattern. Each of its four states records the longest tail of the received stream that is also a leading part of the pattern:

- `ST_NONE`: no progress.
- `ST_ONE`: tail is 1.
- `ST_ONEZERO`: tail is 1,0.
- `ST_ONEZEROONE`: tail is 1,0,1.

The transitions are:

| From | Input 1 | Input 0 |
|---|---|---|
| `ST_NONE` | `ST_ONE` | stays in `ST_NONE` |
| `ST_ONE` | stays in `ST_ONE` | `ST_ONEZERO` |
| `ST_ONEZERO` | `ST_ONEZEROONE` | back to `ST_NONE` |
| `ST_ONEZEROONE` | falls back to `ST_ONE` | `ST_ONEZERO`, and this is the hit |

The flag is formed from the current state and the current input bit. It is therefore high during the same cycle in which the closing 0 is presented, before the clock edge that takes that bit in. A synchronous reset returns the machine to `ST_NONE`. The flag is held low while reset is high.

Top module: `pat1010_detector`

## Requirements
- R1: `detect` is 1 in a cycle exactly when `din` is 0 in that cycle and the three bits accepted at the three preceding rising edges since reset were 1, 0, 1 (oldest first).
- R2: Overlap is honoured. After a hit the machine is in `ST_ONEZERO`, so the input 1,0,1,0,1,0 gives hits on its 4th and 6th bits.
- R3: A cycle with `din` = 1 never shows `detect` = 1. In every cycle that does not complete the pattern, `detect` is 0.
- R4: A rising edge with `rst` = 1 puts the machine in `ST_NONE`. Bits received before the reset never count toward a later hit.
- R5: `detect` is 0 in every cycle in which `rst` is 1, whatever the state and `din`.
- R6: The stream 0101011001010100 (first bit leftmost), sent after reset, gives hits on exactly its 5th, 13th and 15th bits.
- R7: A broken prefix restarts correctly. A second consecutive 1 keeps the machine in `ST_ONE`, and 1,0,0 returns it to `ST_NONE`. So 1,1,0,1,0 hits on its 5th bit, and 1,0,0,1,0,1,0 hits only on its 7th bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, one per clock |
| detect | output | 1 | High in the cycle whose input completes 1,0,1,0 |

## Verification
Clean single patterns show that a hit appears on the closing 0 of a match and nowhere else. The stream 101010 separates an overlapping machine from one that restarts from scratch after each hit. The strings 11010 and 1001010 catch wrong fall-back targets, one after a repeated 1 and one after a double 0. The 16-bit reference stream and a long pseudo-random stream compare every cycle against a model that only remembers the last three accepted bits. A reset placed in the middle of a partial match shows both that the flag is gated during reset and that earlier history is discarded.

// File: rtl/pat1010_pkg.sv
package pat1010_pkg;

    // Progress through the pattern: longest received suffix that is a prefix
    typedef enum logic [1:0] {
        ST_NONE       = 2'd0,
        ST_ONE        = 2'd1,
        ST_ONEZERO    = 2'd2,
        ST_ONEZEROONE = 2'd3
    } prog_e;

endpackage

// File: rtl/pat1010_next.sv
module pat1010_next
    import pat1010_pkg::*;
(
    input  prog_e cur,
    input  logic  bit_in,
    output prog_e nxt
);

    always_comb begin
        nxt = ST_NONE;
        unique case (cur)
            ST_NONE:       nxt = bit_in ? ST_ONE        : ST_NONE;
            ST_ONE:        nxt = bit_in ? ST_ONE        : ST_ONEZERO;
            ST_ONEZERO:    nxt = bit_in ? ST_ONEZEROONE : ST_NONE;
            ST_ONEZEROONE: nxt = bit_in ? ST_ONE        : ST_ONEZERO; // hit keeps "10"
            default:       nxt = ST_NONE;
        endcase
    end

endmodule

// File: rtl/pat1010_streg.sv
module pat1010_streg
    import pat1010_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prog_e nxt,
    output prog_e cur
);

    always_ff @(posedge clk) begin
        if (rst) cur <= ST_NONE;
        else     cur <= nxt;
    end

endmodule

// File: rtl/pat1010_out.sv
module pat1010_out
    import pat1010_pkg::*;
(
    input  logic  rst,
    input  prog_e cur,
    input  logic  bit_in,
    output logic  hit
);

    // Mealy output: the closing 0 arrives while three bits of progress are held
    always_comb begin
        hit = 1'b0;
        unique case (cur)
            ST_ONEZEROONE: hit = !bit_in && !rst;
            ST_NONE, ST_ONE, ST_ONEZERO: hit = 1'b0;
            default:       hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pat1010_detector.sv
module pat1010_detector
    import pat1010_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic detect
);

    prog_e cur_state;
    prog_e nxt_state;

    pat1010_next u_next (
        .cur    (cur_state),
        .bit_in (din),
        .nxt    (nxt_state)
    );

    pat1010_streg u_streg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_state),
        .cur (cur_state)
    );

    pat1010_out u_out (
        .rst    (rst),
        .cur    (cur_state),
        .bit_in (din),
        .hit    (detect)
    );

endmodule

// File: rtl/pat1010_checker.sv
module pat1010_checker
    import pat1010_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  din,
    input logic  detect,
    input prog_e state
);

    // R1: a hit is preceded by accepted bits 1,0,1
    p_hit_history_r1: assert property (@(posedge clk) disable iff (rst)
        detect |-> ($past(din, 3) && !$past(din, 2) && $past(din, 1)));

    // R2: after a hit the machine keeps the "10" suffix
    p_overlap_keep_r2: assert property (@(posedge clk) disable iff (rst)
        detect |=> (state == ST_ONEZERO));

    // R3: a 1 on the input never completes the pattern
    p_hit_on_zero_r3: assert property (@(posedge clk) disable iff (rst)
        detect |-> !din);

    // R4: reset edge lands in the idle state
    p_reset_idle_r4: assert property (@(posedge clk)
        rst |=> (state == ST_NONE));

    // R5: flag silent during reset
    p_reset_quiet_r5: assert property (@(posedge clk)
        rst |-> !detect);

    // R7: 1,0 followed by 0 discards all progress
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ONEZERO && !din) |=> (state == ST_NONE));

endmodule

bind pat1010_detector pat1010_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .detect (detect),
    .state  (cur_state)
);

// File: tb/test_pat1010_detector.sv
module test_pat1010_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic detect;

    int checks = 0;
    int fails  = 0;
    int hist[$];

    always #5 clk = ~clk;

    pat1010_detector i_pat1010_detector (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .detect (detect)
    );

    // One cycle: drive on falling edge, check mid-cycle, update model on rising edge
    task automatic apply(input logic b, input logic r, input string tag);
        logic exp;
        @(negedge clk);
        din = b;
        rst = r;
        #2;
        exp = !r && (hist.size() >= 3) && hist[hist.size()-3] == 1 &&
              hist[hist.size()-2] == 0 && hist[hist.size()-1] == 1 && !b;
        checks++;
        if (detect !== exp) begin
            fails++;
            $display("FAIL %s: detect=%b expected %b (din=%b rst=%b)", tag, detect, exp, b, r);
        end
        @(posedge clk);
        if (r) hist.delete();
        else begin
            hist.push_back(int'(b));
            if (hist.size() > 8) void'(hist.pop_front());
        end
    endtask

    task automatic send(input logic [31:0] v, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) apply(v[i], 1'b0, tag);
    endtask

    task automatic reset_cycle(input string tag);
        apply(1'b0, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lfsr;
        // R4 / R5: reset state
        apply(1'b0, 1'b1, "R4");
        apply(1'b1, 1'b1, "R5");
        // R1: single clean match
        send(32'b1010, 4, "R1");
        reset_cycle("R4");
        // R2: overlapping matches
        send(32'b101010, 6, "R2");
        send(32'b1010, 4, "R2");
        reset_cycle("R4");
        // R6: reference stream
        send(32'b0101011001010100, 16, "R6");
        reset_cycle("R4");
        // R7: broken prefixes
        send(32'b11010, 5, "R7");
        reset_cycle("R4");
        send(32'b1001010, 7, "R7");
        send(32'b1011010, 7, "R7");
        // R3: streams without a match
        send(32'hFF, 8, "R3");
        send(32'h00, 8, "R3");
        send(32'b10110110, 8, "R3");
        // R5: reset while the closing 0 is presented after 1,0,1
        send(32'b101, 3, "R5");
        apply(1'b0, 1'b1, "R5");
        // R4: history before reset is forgotten
        send(32'b101, 3, "R4");
        apply(1'b1, 1'b1, "R5");
        apply(1'b0, 1'b0, "R4");
        send(32'b10, 2, "R4");
        // R1: long pseudo-random stream
        lfsr = 32'h1ACE;
        for (int k = 0; k < 600; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            apply(lfsr[0] ^ lfsr[3], 1'b0, "R1");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule